// File: doc/BRIEF.md
# Genlock Frame Buffer Pointer Controller

This block decides which entry of a circular set of frame stores a video channel writes or reads next, and when the next frame begins. It works in one of four synchronisation roles. As a fixed master it steps through the stores on its own. As a fixed slave it trails a partner's pointer by a programmable number of frames. As a dynamic master it steps forward but steps around the store the partner holds. As a dynamic slave it takes the partner's pointer directly. The partner's pointer comes in on one port, and the block's own pointer goes out on another, so two instances can be cross-wired as a writer and a reader.

A frame starts in one of three ways: at once whenever the channel is idle (free run), on a falling edge of an external sync line, or when the incoming stream's start-of-frame flag is seen high. On each start the block issues a one-cycle strobe together with the selected store index. In free run it also emits a one-cycle start-of-frame marker for downstream logic. The transfer logic reports the end of a frame with a one-cycle done pulse.

Top module: `gl_frame_ptr_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, buf_idx, ptr_out, frame_start, sof_mark and collision are all 0, and the channel is idle.
- R2: Store indices stay below the configured store count (1 to 32; a value of 0 is treated as 1), and incrementing past the last store wraps to 0.
- R3: Role code 0 (fixed master), and any role with genlock disabled (cfg_genlock_en = 0), selects the current index plus one on every frame start, whatever partner_ptr is. In all roles except dynamic master, ptr_out equals buf_idx.
- R4: Role code 1 (fixed slave) with genlock enabled selects (partner_ptr − cfg_delay) modulo the store count. The index repeats when the partner has not moved and skips when it has moved by more than one.
- R5: Role code 3 (dynamic slave) with genlock enabled selects partner_ptr modulo the store count.
- R6: Role code 2 (dynamic master) with genlock enabled selects the current index plus one. If that equals partner_ptr, it selects the index after that instead. Its ptr_out is the index of the last frame that completed, meaning the buf_idx captured when frame_done was seen during a frame.
- R7: A dynamic master with genlock enabled and a store count of 1 selects index 0 and raises collision. The collision flag is re-evaluated at every frame start, so it clears at the next start that has no conflict.
- R8: Sync code 0 (free run) starts a frame on the clock edge after the one that sampled frame_done, or on the first edge at which the channel is idle. It does not start on the edge that samples frame_done.
- R9: Sync code 1 (external) starts a frame on the edge after ext_sync goes from 1 to 0 while the channel is idle. A rising edge does nothing, and a falling edge during a frame is ignored.
- R10: Sync code 2 (stream start) starts a frame on the edge after sof_flag is sampled high while the channel is idle, and not before.
- R11: sof_mark is high for exactly the cycle of frame_start when the sync code is 0, and stays 0 under the other sync codes.
- R12: frame_start is a one-cycle strobe; it never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_role | input | 2 | 0 fixed master, 1 fixed slave, 2 dynamic master, 3 dynamic slave |
| cfg_sync | input | 2 | 0 free run, 1 external falling edge, 2 stream start flag, 3 never start |
| cfg_genlock_en | input | 1 | Enables partner-aware index selection |
| cfg_num_bufs | input | 6 | Number of frame stores, 1 to 32 |
| cfg_delay | input | 5 | Frame lag of the fixed slave behind its partner |
| frame_done | input | 1 | One-cycle pulse at the end of the current frame |
| ext_sync | input | 1 | External frame sync line |
| sof_flag | input | 1 | Start-of-frame flag of the incoming stream |
| partner_ptr | input | 5 | Pointer published by the partner channel |
| buf_idx | output | 5 | Store index of the current frame |
| ptr_out | output | 5 | Pointer published to the partner |
| frame_start | output | 1 | One-cycle strobe when a frame begins |
| sof_mark | output | 1 | One-cycle start-of-frame marker in free run |
| collision | output | 1 | Dynamic master forced to share the single store |

## Verification
The bench steps the channel through the four roles. The fixed slave's subtraction is driven below zero, so a design that wraps it wrongly or forgets the modulo produces an index past the last store. The dynamic master is placed with the partner sitting just ahead of it, including a wrap to 0 and a two-store set. A design that skips blindly, or skips without wrapping, picks the wrong store or the partner's own store. With one store, a design that keeps stepping, or that latches collision for good, shows up on the collision output. The trigger tests present a rising edge on the external sync line and a falling edge during a frame. They also check that a free-run start never lands in the same cycle as frame_done, which is where an edge-detect or idle-gating mistake would show.

// File: rtl/gl_fbp_pkg.sv
package gl_fbp_pkg;

    localparam int FBP_MAX_BUFS = 32;
    localparam int IDX_W        = $clog2(FBP_MAX_BUFS);
    localparam int CNT_W        = $clog2(FBP_MAX_BUFS + 1);

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        ROLE_MASTER     = 2'd0,
        ROLE_SLAVE      = 2'd1,
        ROLE_DYN_MASTER = 2'd2,
        ROLE_DYN_SLAVE  = 2'd3
    } role_e;

    typedef enum logic [1:0] {
        SYNC_FREE = 2'd0,
        SYNC_EXT  = 2'd1,
        SYNC_SOF  = 2'd2,
        SYNC_OFF  = 2'd3
    } sync_e;

    typedef struct packed {
        idx_t idx;
        logic collide;
    } sel_t;

    // Clamp a configured store count into 1..FBP_MAX_BUFS
    function automatic cnt_t eff_count(input cnt_t n);
        if (n == '0)
            return cnt_t'(1);
        else if (n > cnt_t'(FBP_MAX_BUFS))
            return cnt_t'(FBP_MAX_BUFS);
        else
            return n;
    endfunction

    // Step forward one store with wrap at the count
    function automatic idx_t wrap_inc(input idx_t cur, input cnt_t n);
        cnt_t t;
        t = {1'b0, cur} + cnt_t'(1);
        if (t >= n)
            return '0;
        else
            return t[IDX_W-1:0];
    endfunction

    // (a - d) modulo n, with both operands reduced first; n is non-zero
    function automatic idx_t wrap_sub(input idx_t a, input idx_t d, input cnt_t n);
        cnt_t am;
        cnt_t dm;
        cnt_t r;
        am = {1'b0, a} % n;
        dm = {1'b0, d} % n;
        if (am >= dm)
            r = am - dm;
        else
            r = am + n - dm;
        return r[IDX_W-1:0];
    endfunction

endpackage

// File: rtl/gl_start_gen.sv
module gl_start_gen
    import gl_fbp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  sync_e sync_mode,
    input  logic  busy,
    input  logic  ext_sync,
    input  logic  sof_flag,
    output logic  trig
);

    logic ext_prev;

    always_ff @(posedge clk) begin
        if (rst)
            ext_prev <= 1'b0;
        else
            ext_prev <= ext_sync;
    end

    always_comb begin
        trig = 1'b0;
        if (!busy) begin
            case (sync_mode)
                SYNC_FREE: trig = 1'b1;
                SYNC_EXT:  trig = ext_prev & ~ext_sync;
                SYNC_SOF:  trig = sof_flag;
                default:   trig = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/gl_index_sel.sv
module gl_index_sel
    import gl_fbp_pkg::*;
(
    input  role_e role,
    input  logic  genlock_en,
    input  cnt_t  num_bufs,
    input  idx_t  delay,
    input  idx_t  partner,
    input  idx_t  cur,
    output sel_t  sel
);

    idx_t step1;
    idx_t step2;

    always_comb begin
        step1 = wrap_inc(cur, num_bufs);
        step2 = wrap_inc(step1, num_bufs);
        sel.idx     = step1;
        sel.collide = 1'b0;
        if (genlock_en) begin
            case (role)
                ROLE_MASTER:    sel.idx = step1;
                ROLE_SLAVE:     sel.idx = wrap_sub(partner, delay, num_bufs);
                ROLE_DYN_SLAVE: sel.idx = wrap_sub(partner, '0, num_bufs);
                ROLE_DYN_MASTER: begin
                    if (num_bufs == cnt_t'(1)) begin
                        sel.idx     = '0;
                        sel.collide = 1'b1;
                    end else if (step1 == partner) begin
                        sel.idx = step2;
                    end else begin
                        sel.idx = step1;
                    end
                end
                default:        sel.idx = step1;
            endcase
        end
    end

endmodule

// File: rtl/gl_frame_ptr_ctrl.sv
module gl_frame_ptr_ctrl
    import gl_fbp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cfg_role,
    input  logic [1:0]       cfg_sync,
    input  logic             cfg_genlock_en,
    input  logic [CNT_W-1:0] cfg_num_bufs,
    input  logic [IDX_W-1:0] cfg_delay,
    input  logic             frame_done,
    input  logic             ext_sync,
    input  logic             sof_flag,
    input  logic [IDX_W-1:0] partner_ptr,
    output logic [IDX_W-1:0] buf_idx,
    output logic [IDX_W-1:0] ptr_out,
    output logic             frame_start,
    output logic             sof_mark,
    output logic             collision
);

    role_e role;
    sync_e sync_mode;
    cnt_t  n_eff;
    logic  busy;
    logic  trig;
    idx_t  done_ptr;
    sel_t  sel;

    assign role      = role_e'(cfg_role);
    assign sync_mode = sync_e'(cfg_sync);
    assign n_eff     = eff_count(cfg_num_bufs);

    gl_start_gen u_start (
        .clk       (clk),
        .rst       (rst),
        .sync_mode (sync_mode),
        .busy      (busy),
        .ext_sync  (ext_sync),
        .sof_flag  (sof_flag),
        .trig      (trig)
    );

    gl_index_sel u_sel (
        .role       (role),
        .genlock_en (cfg_genlock_en),
        .num_bufs   (n_eff),
        .delay      (cfg_delay),
        .partner    (partner_ptr),
        .cur        (buf_idx),
        .sel        (sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy        <= 1'b0;
            buf_idx     <= '0;
            done_ptr    <= '0;
            frame_start <= 1'b0;
            sof_mark    <= 1'b0;
            collision   <= 1'b0;
        end else begin
            frame_start <= trig;
            sof_mark    <= trig && (sync_mode == SYNC_FREE);
            if (trig) begin
                busy      <= 1'b1;
                buf_idx   <= sel.idx;
                collision <= sel.collide;
            end else if (frame_done && busy) begin
                busy     <= 1'b0;
                done_ptr <= buf_idx;
            end
        end
    end

    assign ptr_out = (role == ROLE_DYN_MASTER) ? done_ptr : buf_idx;

endmodule

// File: rtl/gl_frame_ptr_ctrl_chk.sv
module gl_frame_ptr_ctrl_chk
    import gl_fbp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [1:0]       cfg_role,
    input logic [1:0]       cfg_sync,
    input logic             cfg_genlock_en,
    input logic [CNT_W-1:0] cfg_num_bufs,
    input logic [IDX_W-1:0] cfg_delay,
    input logic             frame_done,
    input logic             ext_sync,
    input logic             sof_flag,
    input logic [IDX_W-1:0] partner_ptr,
    input logic [IDX_W-1:0] buf_idx,
    input logic [IDX_W-1:0] ptr_out,
    input logic             frame_start,
    input logic             sof_mark,
    input logic             collision
);

    // R12
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

    // R11
    sof_mark_chk: assert property (@(posedge clk) disable iff (rst)
        sof_mark |-> frame_start);

    // R2
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> ({1'b0, buf_idx} < eff_count($past(cfg_num_bufs))));

    // R7
    collision_idx_chk: assert property (@(posedge clk) disable iff (rst)
        collision |-> (buf_idx == '0));

    // R9
    ext_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_start && ($past(cfg_sync) == 2'd1)) |-> (!$past(ext_sync) && $past(ext_sync, 2)));

    // R10
    sof_trigger_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_start && ($past(cfg_sync) == 2'd2)) |-> $past(sof_flag));

endmodule

bind gl_frame_ptr_ctrl gl_frame_ptr_ctrl_chk chk_i (.*);

// File: tb/gl_frame_ptr_ctrl_tb_top.sv
module gl_frame_ptr_ctrl_tb_top;
    import gl_fbp_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 15;

    typedef struct packed {
        logic [1:0] role;
        logic       gl;
        logic [5:0] nb;
        logic [4:0] dly;
        logic [4:0] part;
        logic [4:0] idx;
        logic [4:0] ptr;
        logic       col;
    } vec_t;

    // Rows chain: each starts from the index the previous row left.
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b1, 6'd3, 5'd0, 5'd0, 5'd2, 5'd2, 1'b0},  // R3 1->2
        '{2'd0, 1'b1, 6'd3, 5'd0, 5'd0, 5'd0, 5'd0, 1'b0},  // R2 wrap 2->0
        '{2'd0, 1'b1, 6'd3, 5'd0, 5'd2, 5'd1, 5'd1, 1'b0},  // R3 partner ignored
        '{2'd1, 1'b0, 6'd3, 5'd1, 5'd0, 5'd2, 5'd2, 1'b0},  // R3 slave w/o genlock
        '{2'd1, 1'b1, 6'd3, 5'd1, 5'd2, 5'd1, 5'd1, 1'b0},  // R4 lag 1
        '{2'd1, 1'b1, 6'd3, 5'd1, 5'd2, 5'd1, 5'd1, 1'b0},  // R4 repeat
        '{2'd1, 1'b1, 6'd3, 5'd1, 5'd0, 5'd2, 5'd2, 1'b0},  // R4 wrap below 0
        '{2'd1, 1'b1, 6'd5, 5'd2, 5'd1, 5'd4, 5'd4, 1'b0},  // R4 skip
        '{2'd3, 1'b1, 6'd5, 5'd0, 5'd2, 5'd2, 5'd2, 1'b0},  // R5
        '{2'd2, 1'b1, 6'd5, 5'd0, 5'd3, 5'd4, 5'd2, 1'b0},  // R6 skip partner
        '{2'd2, 1'b1, 6'd5, 5'd0, 5'd0, 5'd1, 5'd4, 1'b0},  // R6 skip with wrap
        '{2'd2, 1'b1, 6'd5, 5'd0, 5'd3, 5'd2, 5'd1, 1'b0},  // R6 no conflict
        '{2'd2, 1'b1, 6'd1, 5'd0, 5'd0, 5'd0, 5'd2, 1'b1},  // R7 single store
        '{2'd2, 1'b0, 6'd3, 5'd0, 5'd1, 5'd1, 5'd0, 1'b0},  // R7 clears, R3 no skip
        '{2'd2, 1'b1, 6'd2, 5'd0, 5'd0, 5'd1, 5'd1, 1'b0}   // R6 two stores
    };

    logic             clk = 1'b0;
    logic             rst;
    logic [1:0]       cfg_role;
    logic [1:0]       cfg_sync;
    logic             cfg_genlock_en;
    logic [CNT_W-1:0] cfg_num_bufs;
    logic [IDX_W-1:0] cfg_delay;
    logic             frame_done;
    logic             ext_sync;
    logic             sof_flag;
    logic [IDX_W-1:0] partner_ptr;
    logic [IDX_W-1:0] buf_idx;
    logic [IDX_W-1:0] ptr_out;
    logic             frame_start;
    logic             sof_mark;
    logic             collision;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gl_frame_ptr_ctrl dut_i (
        .clk            (clk),
        .rst            (rst),
        .cfg_role       (cfg_role),
        .cfg_sync       (cfg_sync),
        .cfg_genlock_en (cfg_genlock_en),
        .cfg_num_bufs   (cfg_num_bufs),
        .cfg_delay      (cfg_delay),
        .frame_done     (frame_done),
        .ext_sync       (ext_sync),
        .sof_flag       (sof_flag),
        .partner_ptr    (partner_ptr),
        .buf_idx        (buf_idx),
        .ptr_out        (ptr_out),
        .frame_start    (frame_start),
        .sof_mark       (sof_mark),
        .collision      (collision)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    function automatic string role_tag(input vec_t v);
        if (!v.gl || v.role == 2'd0) return "R3";
        if (v.role == 2'd1)          return "R4";
        if (v.role == 2'd3)          return "R5";
        return "R6";
    endfunction

    // Ends the running frame in free run and checks the next start.
    task automatic run_frame(input vec_t v);
        string tag;
        tag = role_tag(v);
        @(negedge clk);
        cfg_role       = v.role;
        cfg_genlock_en = v.gl;
        cfg_num_bufs   = v.nb;
        cfg_delay      = v.dly;
        partner_ptr    = v.part;
        frame_done     = 1'b1;
        @(posedge clk); #1;
        chk(frame_start == 1'b0, "R8 no start on done edge", int'(frame_start), 0);
        @(negedge clk);
        frame_done = 1'b0;
        @(posedge clk); #1;
        chk(frame_start == 1'b1, "R8 start after done", int'(frame_start), 1);
        chk(buf_idx == v.idx, {tag, " R2 buf_idx"}, int'(buf_idx), int'(v.idx));
        chk(ptr_out == v.ptr, {tag, " ptr_out"}, int'(ptr_out), int'(v.ptr));
        chk(collision == v.col, "R7 collision", int'(collision), int'(v.col));
        chk(sof_mark == 1'b1, "R11 free-run marker", int'(sof_mark), 1);
        @(posedge clk); #1;
        chk(frame_start == 1'b0, "R12 strobe width", int'(frame_start), 0);
        chk(sof_mark == 1'b0, "R11 marker width", int'(sof_mark), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        rst            = 1'b1;
        cfg_role       = 2'd0;
        cfg_sync       = 2'd1;
        cfg_genlock_en = 1'b1;
        cfg_num_bufs   = 6'd3;
        cfg_delay      = '0;
        frame_done     = 1'b0;
        ext_sync       = 1'b0;
        sof_flag       = 1'b0;
        partner_ptr    = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(buf_idx == '0,      "R1 buf_idx",     int'(buf_idx), 0);
        chk(ptr_out == '0,      "R1 ptr_out",     int'(ptr_out), 0);
        chk(frame_start == 1'b0, "R1 frame_start", int'(frame_start), 0);
        chk(sof_mark == 1'b0,   "R1 sof_mark",    int'(sof_mark), 0);
        chk(collision == 1'b0,  "R1 collision",   int'(collision), 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        chk(frame_start == 1'b0, "R1 idle after reset", int'(frame_start), 0);

        // R8: free run starts at once from idle
        @(negedge clk);
        cfg_sync = 2'd0;
        @(posedge clk); #1;
        chk(frame_start == 1'b1 && buf_idx == 5'd1, "R8 idle start", int'(buf_idx), 1);

        for (int i = 0; i < NV; i++) begin
            run_frame(VEC[i]);
        end

        // R9: external sync, master, four stores; current index is 1
        @(negedge clk);
        cfg_role = 2'd0; cfg_genlock_en = 1'b1; cfg_num_bufs = 6'd4;
        cfg_sync = 2'd1; ext_sync = 1'b0; frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(frame_start == 1'b0 && buf_idx == 5'd1, "R9 no edge no start", int'(frame_start), 0);
        @(negedge clk);
        ext_sync = 1'b1;
        @(posedge clk); #1;
        chk(frame_start == 1'b0, "R9 rising edge ignored", int'(frame_start), 0);
        @(negedge clk);
        ext_sync = 1'b0;
        @(posedge clk); #1;
        chk(frame_start == 1'b1 && buf_idx == 5'd2, "R9 falling edge start", int'(buf_idx), 2);
        chk(sof_mark == 1'b0, "R11 no marker under external sync", int'(sof_mark), 0);
        @(negedge clk);
        ext_sync = 1'b1;
        @(negedge clk);
        ext_sync = 1'b0;
        @(posedge clk); #1;
        chk(frame_start == 1'b0, "R9 edge during frame ignored", int'(frame_start), 0);
        @(posedge clk); #1;
        chk(frame_start == 1'b0 && buf_idx == 5'd2, "R9 index held while busy", int'(buf_idx), 2);

        // R10: stream start flag
        @(negedge clk);
        cfg_sync = 2'd2; sof_flag = 1'b0; frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk(frame_start == 1'b0, "R10 waits for flag", int'(frame_start), 0);
        @(negedge clk);
        sof_flag = 1'b1;
        @(posedge clk); #1;
        chk(frame_start == 1'b1 && buf_idx == 5'd3, "R10 flag start", int'(buf_idx), 3);
        chk(sof_mark == 1'b0, "R11 no marker under stream start", int'(sof_mark), 0);
        @(negedge clk);
        sof_flag = 1'b0;

        // R1: reset mid-run returns to the reset state
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        chk(buf_idx == '0 && frame_start == 1'b0, "R1 reset mid-run", int'(buf_idx), 0);

        finish_run();
    end

endmodule